// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single shared data line. The port also generates the shift clock on a second pin. The clock runs at a fixed rate: one bit period lasts twelve core clocks. Within each bit period the clock is low for six cycles and then high for six cycles. Bits travel least significant first. Transmit data changes only while the clock is low. Receive data is taken at the moment the clock rises.

The host starts a transmission by writing a byte. It starts a reception by raising the receive enable while the receive flag is clear. Each direction has a completion flag. A flag stays set until the host pulses the matching clear input. While the receive flag is set, no new reception can start, so an unread byte is never overwritten. The data pin's output enable is high only during a transmission. During a reception the pin is released so that another device can drive it.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the shift clock output is 1, the output enable is 0, the data output is 0, both completion flags are 0 and the receive buffer reads 0x00.
- R2: When `host_wr` is 1 at a clock edge while the port is idle, a transmission of `host_wdata` starts. The output enable is 1 for the next 96 cycles. During transfer cycles 12i to 12i+11, `dat_o` carries data bit i, for i from 0 to 7.
- R3: During a transfer, the shift clock is 0 for cycles 0 to 5 of each 12-cycle bit period and 1 for cycles 6 to 11. While the port is idle the shift clock is 1.
- R4: The transmit flag becomes 1 on the clock edge 96 cycles after the edge that started the transmission. It then stays 1 until a clock edge sees `tx_flag_clr` at 1. If a clear and a completion fall on the same edge, the flag ends at 1.
- R5: A reception starts at a clock edge where the port is idle, `rx_en` is 1, the receive flag is 0 and `host_wr` is 0. During the reception the output enable stays 0.
- R6: During a reception, data bit i is the value of `dat_i` at the edge that ends transfer cycle 12i+5, which is where the shift clock rises. `rdata` bit i and the receive flag both change on the edge 96 cycles after the reception started.
- R7: While the receive flag is 1, no reception starts. The receive flag stays set until a clock edge sees `rx_flag_clr` at 1, with completion winning over a clear on the same edge. After a clear, if `rx_en` is still 1, the next reception starts on the following edge.
- R8: A host write during a transfer in either direction is ignored. When a write and the conditions for a receive start fall on the same idle edge, the transmission wins.
- R9: `dat_i` has no effect outside a reception. A transmission leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the transmit byte |
| host_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable level |
| tx_flag_clr | input | 1 | Clears the transmit-complete flag |
| rx_flag_clr | input | 1 | Clears the receive-complete flag |
| rdata | output | 8 | Last received byte |
| tx_done_flag | output | 1 | Transmit complete, sticky |
| rx_done_flag | output | 1 | Receive complete, sticky |
| dat_i | input | 1 | Data pin input value |
| dat_o | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock output |

## Verification
The first output changes in the cycle directly after the edge that starts a transfer. At that point the clock goes low, and for a transmission the enable and bit 0 also appear. The shift clock rises six cycles into each bit period. Receive capture happens on that same edge. Both the completion flag and the receive buffer are due exactly 96 cycles after the start edge. A clear pulse takes effect on the next edge.

The bench's reference model counts elapsed transfer cycles from the edge on which it sees the start condition. It is compared with every output at each falling edge. Inputs change only on falling edges, so every register on the path has settled before the comparison. The stimulus deliberately places a flag clear on the completion edge, a write in the same cycle as a receive arm, and writes in the middle of transfers.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_TX   = 2'd1,
    XF_RX   = 2'd2
  } xfer_e;

  // level of the shift clock for a phase inside one bit period
  function automatic logic clk_level(input int unsigned phase, input int unsigned half);
    return (phase >= half);
  endfunction

  // phase whose closing edge is the rising edge of the shift clock
  function automatic logic is_sample_phase(input int unsigned phase, input int unsigned half);
    return (phase == half - 1);
  endfunction

  // phase whose closing edge ends the bit period
  function automatic logic is_last_phase(input int unsigned phase, input int unsigned div);
    return (phase == div - 1);
  endfunction

endpackage

// File: rtl/ssp_bitclk.sv
module ssp_bitclk #(
  parameter int DIV    = 12,
  parameter int DATA_W = 8,
  localparam int PH_W  = $clog2(DIV),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [PH_W-1:0]  phase,
  output logic [BIT_W-1:0] bit_idx,
  output logic             sample_tick,
  output logic             last_tick,
  output logic             done_tick
);
  import ssp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (run) begin
      if (last_tick) begin
        phase   <= '0;
        bit_idx <= bit_idx + BIT_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  assign sample_tick = run && is_sample_phase(32'(phase), DIV / 2);
  assign last_tick   = run && is_last_phase(32'(phase), DIV);
  assign done_tick   = last_tick && (bit_idx == BIT_W'(DATA_W - 1));

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            rx_en,
  input  logic            tx_flag_clr,
  input  logic            rx_flag_clr,
  input  logic            done_tick,
  output ssp_pkg::xfer_e  state,
  output logic            start_tx,
  output logic            start_rx,
  output logic            tx_flag,
  output logic            rx_flag
);
  import ssp_pkg::*;

  logic idle;
  assign idle     = (state == XF_IDLE);
  assign start_tx = idle && host_wr;
  assign start_rx = idle && !host_wr && rx_en && !rx_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= XF_IDLE;
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      tx_flag <= (tx_flag && !tx_flag_clr) || (done_tick && state == XF_TX);
      rx_flag <= (rx_flag && !rx_flag_clr) || (done_tick && state == XF_RX);
      if (start_tx)       state <= XF_TX;
      else if (start_rx)  state <= XF_RX;
      else if (done_tick) state <= XF_IDLE;
    end
  end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clear_rx,
  input  logic              shift_tx,
  input  logic              capture_rx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              dat_i,
  input  logic              commit_rx,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rbuf
);

  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      rbuf <= '0;
    end else begin
      if (load_tx)         sreg <= wdata;
      else if (clear_rx)   sreg <= '0;
      else if (shift_tx)   sreg <= {1'b0, sreg[DATA_W-1:1]};
      else if (capture_rx) sreg[bit_idx] <= dat_i;
      if (commit_rx) rbuf <= sreg;
    end
  end

  assign tx_bit = sreg[0];

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_W = 8,
  parameter int DIV    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rx_en,
  input  logic              tx_flag_clr,
  input  logic              rx_flag_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_done_flag,
  output logic              rx_done_flag,
  input  logic              dat_i,
  output logic              dat_o,
  output logic              dat_oe,
  output logic              sclk_o
);
  import ssp_pkg::*;

  localparam int PH_W  = $clog2(DIV);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int HALF  = DIV / 2;

  xfer_e            state;
  logic             start_tx, start_rx, xfer_start;
  logic             busy_w, in_tx, in_rx;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bit_idx;
  logic             sample_tick, last_tick, xfer_done;
  logic             tx_bit;

  assign in_tx      = (state == XF_TX);
  assign in_rx      = (state == XF_RX);
  assign busy_w     = in_tx || in_rx;
  assign xfer_start = start_tx || start_rx;

  ssp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .rx_en       (rx_en),
    .tx_flag_clr (tx_flag_clr),
    .rx_flag_clr (rx_flag_clr),
    .done_tick   (xfer_done),
    .state       (state),
    .start_tx    (start_tx),
    .start_rx    (start_rx),
    .tx_flag     (tx_done_flag),
    .rx_flag     (rx_done_flag)
  );

  ssp_bitclk #(.DIV(DIV), .DATA_W(DATA_W)) u_bitclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (xfer_start),
    .run         (busy_w),
    .phase       (phase),
    .bit_idx     (bit_idx),
    .sample_tick (sample_tick),
    .last_tick   (last_tick),
    .done_tick   (xfer_done)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_tx    (start_tx),
    .wdata      (host_wdata),
    .clear_rx   (start_rx),
    .shift_tx   (in_tx && last_tick && !xfer_done),
    .capture_rx (in_rx && sample_tick),
    .bit_idx    (bit_idx),
    .dat_i      (dat_i),
    .commit_rx  (in_rx && xfer_done),
    .tx_bit     (tx_bit),
    .rbuf       (rdata)
  );

  assign sclk_o = !busy_w || clk_level(32'(phase), HALF);
  assign dat_oe = in_tx;
  assign dat_o  = in_tx && tx_bit;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_o,
  input logic              dat_oe,
  input logic              dat_o,
  input logic              tx_done_flag,
  input logic              rx_done_flag,
  input logic              tx_flag_clr,
  input logic              rx_flag_clr,
  input logic              busy,
  input logic              start_rx,
  input logic              xfer_done,
  input logic [DATA_W-1:0] rdata
);

  a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);

  a_r2_data_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && $past(dat_oe) && sclk_o && $past(sclk_o)) |-> $stable(dat_o));

  a_r4_tx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_flag && !tx_flag_clr) |=> tx_done_flag);

  a_r7_rx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_flag && !rx_flag_clr) |=> rx_done_flag);

  a_r7_no_arm_while_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_flag |-> !start_rx);

  a_r5_pin_released_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    start_rx |=> !dat_oe);

  a_r6_rdata_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> $stable(rdata));

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> busy);

endmodule

bind sync_shift_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk_o       (sclk_o),
  .dat_oe       (dat_oe),
  .dat_o        (dat_o),
  .tx_done_flag (tx_done_flag),
  .rx_done_flag (rx_done_flag),
  .tx_flag_clr  (tx_flag_clr),
  .rx_flag_clr  (rx_flag_clr),
  .busy         (busy_w),
  .start_rx     (start_rx),
  .xfer_done    (xfer_done),
  .rdata        (rdata)
);

// File: tb/sync_shift_port_bench.sv
module sync_shift_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       rx_en = 1'b0;
  logic       tx_flag_clr = 1'b0;
  logic       rx_flag_clr = 1'b0;
  logic       dat_i = 1'b0;
  logic [7:0] rdata;
  logic       tx_done_flag, rx_done_flag, dat_o, dat_oe, sclk_o;

  always #4 clk = ~clk;

  sync_shift_port u_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .rx_en(rx_en), .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
    .rdata(rdata), .tx_done_flag(tx_done_flag), .rx_done_flag(rx_done_flag),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .sclk_o(sclk_o)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // reference model: 0 idle, 1 transmit, 2 receive; m_t counts transfer cycles
  int         m_mode, m_t;
  logic [7:0] m_txb, m_acc, m_rbuf, rx_pat, noise;
  logic       m_txf, m_rxf, old_rxf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_txb = 0; m_acc = 0; m_rbuf = 0;
      m_txf = 0; m_rxf = 0;
    end else begin
      old_rxf = m_rxf;
      if (tx_flag_clr) m_txf = 0;
      if (rx_flag_clr) m_rxf = 0;
      if (m_mode != 0) begin
        if (m_mode == 2 && (m_t % 12) == 5) m_acc[m_t / 12] = dat_i;
        if (m_t == 95) begin
          if (m_mode == 1) m_txf = 1;
          else begin m_rbuf = m_acc; m_rxf = 1; end
          m_mode = 0;
        end else m_t++;
      end else if (host_wr) begin
        m_mode = 1; m_t = 0; m_txb = host_wdata;
      end else if (rx_en && !old_rxf) begin
        m_mode = 2; m_t = 0; m_acc = 0;
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act %h exp %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every output on each falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("sclk_o R3", {7'd0, sclk_o}, {7'd0, !(m_mode != 0 && (m_t % 12) < 6)});
      chk("dat_oe R2/R5", {7'd0, dat_oe}, {7'd0, m_mode == 1});
      chk("dat_o R2", {7'd0, dat_o}, {7'd0, m_mode == 1 ? m_txb[m_t / 12] : 1'b0});
      chk("tx_flag R4", {7'd0, tx_done_flag}, {7'd0, m_txf});
      chk("rx_flag R7", {7'd0, rx_done_flag}, {7'd0, m_rxf});
      chk("rdata R6/R9", rdata, m_rbuf);
    end
  end

  // line driver: pattern during a reception, noise otherwise (R9)
  always @(negedge clk) begin
    noise = {noise[6:0], noise[7] ^ noise[5] ^ noise[4] ^ noise[3]};
    if (m_mode == 2) dat_i = rx_pat[m_t / 12];
    else dat_i = noise[0];
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_wdata = ~d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    noise = 8'h5B;
    rx_pat = 8'h00;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("reset sclk_o R1", {7'd0, sclk_o}, 8'd1);
    chk("reset dat_oe R1", {7'd0, dat_oe}, 8'd0);
    chk("reset flags R1", {6'd0, tx_done_flag, rx_done_flag}, 8'd0);
    chk("reset rdata R1", rdata, 8'h00);
    idle(4);

    // R2 R3 R9: transmit under line noise
    cur_req = "R2";
    pulse_wr(8'hA5);
    idle(110);
    chk("tx flag after 0xA5 R4", {7'd0, tx_done_flag}, 8'd1);

    // R4: clear on the completion edge, set wins
    cur_req = "R4";
    pulse_wr(8'h3E);
    idle(95);
    tx_flag_clr = 1'b1;
    @(negedge clk); tx_flag_clr = 1'b0;
    idle(5);
    chk("flag after clear on done edge R4", {7'd0, tx_done_flag}, 8'd1);
    tx_flag_clr = 1'b1; @(negedge clk); tx_flag_clr = 1'b0;
    idle(2);
    chk("flag after plain clear R4", {7'd0, tx_done_flag}, 8'd0);

    // R8: write during a transmission is ignored
    cur_req = "R8";
    pulse_wr(8'h81);
    idle(30);
    pulse_wr(8'h7E);
    idle(80);

    // R5 R6: receive
    cur_req = "R6";
    rx_pat = 8'h3C;
    rx_en = 1'b1;
    idle(100);
    chk("rdata 0x3C R6", rdata, 8'h3C);

    // R7: no re-arm while flag set, then clear re-arms
    cur_req = "R7";
    idle(40);
    rx_pat = 8'hC3;
    rx_flag_clr = 1'b1; @(negedge clk); rx_flag_clr = 1'b0;
    idle(20);
    rx_en = 1'b0;
    cur_req = "R8";
    pulse_wr(8'hFF);
    idle(90);
    chk("rdata 0xC3 R7", rdata, 8'hC3);
    chk("rx flag set R7", {7'd0, rx_done_flag}, 8'd1);

    // R8 priority: write and receive arm on the same idle edge
    rx_flag_clr = 1'b1; @(negedge clk); rx_flag_clr = 1'b0;
    cur_req = "R8";
    rx_pat = 8'h96;
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'h4D; rx_en = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    idle(100);
    cur_req = "R9";
    chk("rdata kept through tx R9", rdata, 8'hC3);
    cur_req = "R5";
    idle(100);
    chk("rdata 0x96 after tx R5", rdata, 8'h96);
    rx_en = 1'b0;
    idle(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule